// File: doc/BRIEF.md
# Decade Time Base Gate Generator

This block is the time base of a universal counter. A single input-enable pulse stream (`tick_i`, one system-clock cycle per input event, with the source already chosen upstream) feeds a chain of cascaded decade stages. The chain is eight stages long by default. Two outputs are taken from the one chain at the same time, and a downstream selector decides which one is used.

The first output is a measurement gate, used for frequency and time interval measurements. Other logic counts events while the gate is open. The second output is a divide-by-N pulse stream, used for totalize measurements. A single code input sets both the gate length and the divide ratio as N = 10^code.

An arm request starts a gate. The gate opens on the first input event after the arm request. That event also clears the chain, which lines up the gate edges with the divider. The gate then stays open for exactly N further events. All outputs are registered on the system clock.

Top module: `decade_timebase`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `gate_o`, `busy_o` and `div_o` are low, and the divider chain holds zero.
- R2: For `code_i` values 0 to STAGES, the ratio is N = 10^code_i. Any larger code value behaves exactly like code STAGES.
- R3: `div_o` is high for one cycle, in the cycle after each input event that brings the count of events since the last chain clear to a multiple of N. The count wraps at 10^STAGES.
- R4: An arm request is taken only while `busy_o` is low. `busy_o` goes high in the cycle after an accepted arm request. An arm request while `busy_o` is high changes neither outputs nor gate length.
- R5: An accepted arm request clears the chain. An input event in the same cycle is not counted, does not open the gate and gives no `div_o` pulse.
- R6: After an accepted arm request, `gate_o` rises in the cycle after the first input event. That event clears the chain again and is not counted.
- R7: `gate_o` falls in the cycle after the N-th counted event, so exactly N input events occur in cycles where `gate_o` is high.
- R8: `gate_o` high implies `busy_o` high, and both fall in the same cycle.
- R9: With no gate in progress, input events keep advancing the chain, and `div_o` pulses continue whatever the gate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Input-enable pulse, one cycle per input event |
| arm_i | input | 1 | Request to start a measurement gate |
| code_i | input | CODE_W | Time base code, N = 10^code |
| gate_o | output | 1 | Measurement gate |
| div_o | output | 1 | Divide-by-N pulse |
| busy_o | output | 1 | High from an accepted arm request until the gate closes |

## Verification
A decade digit that skips or repeats a value moves every later `div_o` pulse. The error shows within N events of the fault, and it stays as a constant phase offset against a simple count of events since the last clear. A stuck gate state shows at once as a wrong event count inside the gate, or as `busy_o` disagreeing with `gate_o` in the next cycle. A wrong saturation of the code shows as a gate length other than 10^STAGES events. The bench builds the block with three decades so that this full gate fits in the run.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/dtb_decade_stage.sv
module dtb_decade_stage
  import dtb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic carry_o
);
  logic [DIGIT_W-1:0] digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                digit_q <= '0;
    else if (clr_i)             digit_q <= '0;
    else if (inc_i) begin
      if (digit_q == DIGIT_MAX) digit_q <= '0;
      else                      digit_q <= digit_q + 1'b1;
    end
  end

  assign carry_o = inc_i && (digit_q == DIGIT_MAX);

  // R3: digit never leaves the decimal range
  a_r3_digit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_q <= DIGIT_MAX);

  // R5: a clear always lands on zero
  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (digit_q == '0));
endmodule

// File: rtl/dtb_term_sel.sv
module dtb_term_sel #(
  parameter int STAGES = 8,
  parameter int CODE_W = 4,
  localparam int SEL_W = $clog2(STAGES + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [STAGES:0]   carry_i,
  output logic              term_o
);
  logic [SEL_W-1:0] sel;

  // Codes past the last stage saturate to the full chain
  always_comb begin
    if (code_i >= CODE_W'(STAGES)) sel = SEL_W'(STAGES);
    else                           sel = code_i[SEL_W-1:0];
    term_o = carry_i[sel];
  end
endmodule

// File: rtl/dtb_gate_fsm.sv
module dtb_gate_fsm
  import dtb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tick_i,
  input  logic term_i,
  output logic clr_o,
  output logic gate_o,
  output logic busy_o
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (arm_i) begin
        state_d = ST_WAIT;
        clr_o   = 1'b1;
      end
      ST_WAIT: if (tick_i) begin
        state_d = ST_OPEN;
        clr_o   = 1'b1;   // sync the chain to the opening event
      end
      ST_OPEN: if (term_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign gate_o = (state_q == ST_OPEN);
  assign busy_o = (state_q != ST_IDLE);

  a_r8_gate_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> busy_o);

  a_r4_busy_from_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(arm_i));

  a_r4_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !tick_i) |=> (state_q == ST_WAIT));

  a_r4_open_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN && !term_i) |=> gate_o);

  a_r6_open_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(tick_i));

  a_r7_close_on_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> ($past(term_i) && !busy_o));
endmodule

// File: rtl/decade_timebase.sv
module decade_timebase #(
  parameter int STAGES = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              gate_o,
  output logic              div_o,
  output logic              busy_o
);
  logic [STAGES:0] carry;
  logic            clr;
  logic            term;
  logic            div_q;

  // A clearing cycle swallows its event
  assign carry[0] = tick_i && !clr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    dtb_decade_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (carry[g]),
      .carry_o(carry[g+1])
    );
  end

  dtb_term_sel #(
    .STAGES(STAGES),
    .CODE_W(CODE_W)
  ) u_term (
    .code_i (code_i),
    .carry_i(carry),
    .term_o (term)
  );

  dtb_gate_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm_i),
    .tick_i(tick_i),
    .term_i(term),
    .clr_o (clr),
    .gate_o(gate_o),
    .busy_o(busy_o)
  );

  // Shaping register for the divided pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= term;
  end

  assign div_o = div_q;

  a_r3_div_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> $past(tick_i));

  a_r5_no_div_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr) |-> !div_o);
endmodule

// File: tb/tb_decade_timebase.sv
module tb_decade_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 3;
  localparam int CODE_W     = 4;
  localparam int WRAP       = 1000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tick_i = 1'b0;
  logic              arm_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic              gate_o, div_o, busy_o;

  int n_vec = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int m_state = 0;   // 0 idle, 1 waiting, 2 open
  bit m_div = 1'b0;
  int gate_ticks = 0;

  decade_timebase #(.STAGES(STAGES), .CODE_W(CODE_W)) dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .arm_i (arm_i),
    .code_i(code_i),
    .gate_o(gate_o),
    .div_o (div_o),
    .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int n_of(int c);
    int e = (c > STAGES) ? STAGES : c;
    int r = 1;
    repeat (e) r = r * 10;
    return r;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit t, bit a, string req);
    int n;
    @(negedge clk);
    tick_i = t;
    arm_i  = a;
    if (gate_o && t) gate_ticks++;
    n = n_of(int'(code_i));
    m_div = 1'b0;
    if (m_state == 0 && a) begin
      m_cnt = 0;
      m_state = 1;
    end else if (t) begin
      if (m_state == 1) begin
        m_cnt = 0;
        m_state = 2;
      end else begin
        m_cnt = (m_cnt + 1) % WRAP;
        if (m_cnt % n == 0) begin
          m_div = 1'b1;
          if (m_state == 2) m_state = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(req, "gate_o", int'(gate_o), int'(m_state == 2));
    chk(req, "busy_o", int'(busy_o), int'(m_state != 0));
    chk(req, "div_o",  int'(div_o),  int'(m_div));
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "gate_o in reset", int'(gate_o), 0);
    chk("R1", "busy_o in reset", int'(busy_o), 0);
    chk("R1", "div_o in reset",  int'(div_o),  0);
    @(negedge clk);
    rst_ni = 1'b1;
    code_i = 4'd1;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, "R1");  // first div after 10 events
  endtask

  task automatic t_free_run();
    code_i = 4'd1;
    for (int i = 0; i < 40; i++) step(i % 4 != 3, 1'b0, "R9");
    code_i = 4'd2;
    for (int i = 0; i < 260; i++) step(i % 3 != 0, 1'b0, "R3");
    code_i = 4'd0;
    for (int i = 0; i < 12; i++) step(i % 2 == 0, 1'b0, "R3");
  endtask

  task automatic t_gate(int code, string req);
    int guard = 0;
    code_i = CODE_W'(code);
    gate_ticks = 0;
    step(1'b0, 1'b1, req);
    while (busy_o && guard < 8000) begin
      step(guard % 5 != 2, 1'b0, req);
      guard++;
    end
    chk(req, "events inside gate", gate_ticks, n_of(code));
    step(1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, "R9");
  endtask

  task automatic t_arm_while_busy();
    code_i = 4'd2;
    gate_ticks = 0;
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4");   // ignored while waiting
    step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, "R6");   // opens; arm ignored
    for (int i = 0; i < 400 && busy_o; i++) step(1'b1, i % 7 == 0, "R4");
    chk("R4", "events inside gate", gate_ticks, 100);
  endtask

  task automatic t_arm_with_tick();
    code_i = 4'd0;
    step(1'b1, 1'b1, "R5");   // event swallowed by the clear
    step(1'b0, 1'b0, "R5");
    chk("R5", "gate still closed", int'(gate_o), 0);
    gate_ticks = 0;
    step(1'b1, 1'b0, "R6");
    step(1'b1, 1'b0, "R7");
    chk("R7", "events inside gate N=1", gate_ticks, 1);
    step(1'b0, 1'b0, "R8");
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_gate(0, "R7");
    t_gate(1, "R6");
    t_gate(2, "R7");
    t_gate(3, "R2");
    t_gate(7, "R2");
    t_gate(15, "R2");
    t_arm_while_busy();
    t_arm_with_tick();
    t_free_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule